// File: doc/BRIEF.md
# Serial Register Access Slave

This block lets an external host reach a bank of up to 32 registers, 25 bits each, over a four-wire serial link. Every access is one 32-bit full-duplex frame sent while chip select is active. The host shifts in a command word made of an operation flag, a 5-bit register address, one spare bit and a 25-bit value. In the same frame, the block shifts back the addressed register's content. Write frames take effect once the 32nd bit has arrived. Frames cut short by chip select are dropped.

The serial pins are oversampled in the system clock domain through two-stage synchronizers, so the whole block runs on one clock. Chip-select polarity comes from a configuration input. A parameter mask picks which addresses have storage; the others read as zero. A local port on the system side lets neighbouring logic read any register and write into it, so hardware can own individual fields.

Top module: `spi_reg_slave`

## Requirements
- R1: After reset every register reads zero on the local port and `spiMiso` is low.
- R2: A complete frame with bit 31 set stores frame bits 24..0 into the register whose address is frame bits 30..26.
- R3: During any frame, the word shifted out MSB first on `spiMiso` is {7'b0, content of the addressed register}. A frame with bit 31 clear changes no register.
- R4: Frame bit 25 is never stored; the stored value depends only on bits 24..0.
- R5: The word returned during a write frame carries the register content from before that write.
- R6: With `csActiveHigh` = 1 a frame is bounded by `spiCs` high, with 0 by `spiCs` low. SCLK edges while chip select is inactive do not change any register.
- R7: A frame that ends before 32 SCLK rising edges changes no register.
- R8: Addresses whose bit in BACKED_MASK is 0 (by default 28 to 31) read as zero on both ports and ignore writes.
- R9: `locRdata` shows the register at `locAddr`. A cycle with `locWe` high writes `locWdata` into that register, and the value is then visible to SPI reads.
- R10: SCLK rising edges after the 32nd in one chip-select assertion are ignored; the frame is decoded from its first 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| csActiveHigh | input | 1 | 1: chip select active high, 0: active low |
| spiSclk | input | 1 | Serial clock from host, idle low, data sampled on rising edge |
| spiCs | input | 1 | Chip select from host |
| spiMosi | input | 1 | Serial data from host, MSB first |
| spiMiso | output | 1 | Serial data to host, changes after the falling SCLK edge |
| locAddr | input | 5 | Local port register address |
| locWe | input | 1 | Local port write enable |
| locWdata | input | 25 | Local port write data |
| locRdata | output | 25 | Local port read data for `locAddr` |

## Verification
Each pin passes through two synchronizer flops and an edge detector, so an internal strobe fires three system clocks after an SCLK edge and `spiMiso` settles four clocks after a falling edge. The bench holds each SCLK half period for eight clocks and samples `spiMiso` just before the next rising edge. A write lands five clocks after the 32nd rising edge. The bench reads the local port only after chip select has been released and several more half periods have passed. Register state is always checked through `locRdata` or through a later read frame, after a full half-period margin.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // Strobes issued by the control unit to the datapath, one cycle wide each.
  typedef struct packed {
    logic startFrame;   // chip select just became active
    logic shiftIn;      // capture one MOSI bit
    logic loadTx;       // address known, fetch register into the TX shifter
    logic shiftOut;     // advance the TX shifter after a falling SCLK edge
    logic commit;       // 32 bits received, apply the frame
  } spiStrobes_t;

endpackage

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 25
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csActiveHigh,
  input  logic        sclkPin,
  input  logic        csPin,
  input  logic        mosiPin,
  output logic        mosiBit,
  output spiStrobes_t strobes
);

  localparam int FRAME_W = ADDR_W + DATA_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(ADDR_W);

  logic [1:0] sclkSync, csSync, mosiSync;
  logic       sclkPrev, csActPrev;
  logic       csAct, sclkRise, sclkFall;
  logic [CNT_W-1:0] bitCnt;
  logic       pendLoad, pendCommit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync  <= '0;
      csSync    <= '0;
      mosiSync  <= '0;
      sclkPrev  <= 1'b0;
      csActPrev <= 1'b0;
    end else begin
      sclkSync  <= {sclkSync[0], sclkPin};
      csSync    <= {csSync[0], csPin};
      mosiSync  <= {mosiSync[0], mosiPin};
      sclkPrev  <= sclkSync[1];
      csActPrev <= csAct;
    end
  end

  always_comb begin
    csAct    = csActiveHigh ? csSync[1] : !csSync[1];
    sclkRise = sclkSync[1] && !sclkPrev;
    sclkFall = !sclkSync[1] && sclkPrev;
    mosiBit  = mosiSync[1];

    strobes.startFrame = csAct && !csActPrev;
    strobes.shiftIn    = csAct && !strobes.startFrame && sclkRise && (bitCnt < CNT_FULL);
    strobes.shiftOut   = csAct && !strobes.startFrame && sclkFall;
    strobes.loadTx     = csAct && pendLoad;
    strobes.commit     = pendCommit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      pendLoad   <= 1'b0;
      pendCommit <= 1'b0;
    end else begin
      if (!csAct || strobes.startFrame) begin
        bitCnt <= '0;
      end else if (strobes.shiftIn) begin
        bitCnt <= bitCnt + 1'b1;
      end
      pendLoad   <= strobes.shiftIn && (bitCnt == CNT_HDR);
      pendCommit <= strobes.shiftIn && (bitCnt == CNT_LAST);
    end
  end

  // R7: a frame is applied only after the full bit count was reached
  a_r7_commit_full : assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> (bitCnt == CNT_FULL));

  // R10: the bit counter never runs past one frame
  a_r10_cnt_bound : assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_FULL);

  // R6: an inactive chip select leaves the counter cleared
  a_r6_idle_clears : assert property (@(posedge clk) disable iff (!rstN)
    !csAct |=> (bitCnt == '0));

endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 25,
  parameter logic [(2**ADDR_W)-1:0] BACKED_MASK = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  spiStrobes_t       strobes,
  input  logic              mosiBit,
  output logic              miso,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              locWe,
  input  logic [DATA_W-1:0] locWdata,
  output logic [DATA_W-1:0] locRdata
);

  localparam int FRAME_W  = ADDR_W + DATA_W + 2;
  localparam int NUM_REGS = 2 ** ADDR_W;

  logic [FRAME_W-1:0] rxShift, txShift;
  logic [NUM_REGS-1:0][DATA_W-1:0] regQ;
  logic [NUM_REGS-1:0] hostWe, locHit;
  logic              hostOp;
  logic [ADDR_W-1:0] hostAddr, peekAddr;
  logic [DATA_W-1:0] hostData;

  assign hostOp   = rxShift[FRAME_W-1];
  assign hostAddr = rxShift[FRAME_W-2 -: ADDR_W];
  assign hostData = rxShift[DATA_W-1:0];
  assign peekAddr = rxShift[ADDR_W-1:0];

  // Per-register write decode; unbacked slots never get an enable.
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_dec
    if (BACKED_MASK[g]) begin : g_backed
      assign hostWe[g] = strobes.commit && hostOp && (hostAddr == ADDR_W'(g));
      assign locHit[g] = locWe && (locAddr == ADDR_W'(g));
    end else begin : g_empty
      assign hostWe[g] = 1'b0;
      assign locHit[g] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (locHit[i]) begin
          regQ[i] <= locWdata;
        end else if (hostWe[i]) begin
          regQ[i] <= hostData;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strobes.shiftIn) begin
      rxShift <= {rxShift[FRAME_W-2:0], mosiBit};
    end
  end

  // The loaded word is the reply shifted by the bits already sent, so the
  // next falling edge presents the spare-bit slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strobes.startFrame) begin
      txShift <= '0;
    end else if (strobes.loadTx) begin
      txShift <= {2'b00, regQ[peekAddr], {ADDR_W{1'b0}}};
    end else if (strobes.shiftOut) begin
      txShift <= {txShift[FRAME_W-2:0], 1'b0};
    end
  end

  assign miso     = txShift[FRAME_W-1];
  assign locRdata = regQ[locAddr];

  // R2: a host write to a backed register lands one cycle after commit
  a_r2_write_lands : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && hostOp && BACKED_MASK[hostAddr] && !(locWe && locAddr == hostAddr))
    |=> (regQ[$past(hostAddr)] == $past(hostData)));

  // R3: a read frame leaves the bank untouched
  a_r3_read_keeps_bank : assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !hostOp && !locWe) |=> $stable(regQ));

  // R8: unbacked addresses always read zero
  a_r8_unbacked_zero : assert property (@(posedge clk) disable iff (!rstN)
    !BACKED_MASK[locAddr] |-> (locRdata == '0));

  // R5: the reply shifter only moves on a frame start, load or falling edge
  a_r5_tx_on_strobe : assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.startFrame || strobes.loadTx || strobes.shiftOut) |=> $stable(txShift));

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 25,
  parameter logic [(2**ADDR_W)-1:0] BACKED_MASK = 32'h0FFF_FFFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csActiveHigh,
  input  logic              spiSclk,
  input  logic              spiCs,
  input  logic              spiMosi,
  output logic              spiMiso,
  input  logic [ADDR_W-1:0] locAddr,
  input  logic              locWe,
  input  logic [DATA_W-1:0] locWdata,
  output logic [DATA_W-1:0] locRdata
);

  spiStrobes_t strobes;
  logic        mosiBit;

  spi_reg_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .csActiveHigh(csActiveHigh),
    .sclkPin     (spiSclk),
    .csPin       (spiCs),
    .mosiPin     (spiMosi),
    .mosiBit     (mosiBit),
    .strobes     (strobes)
  );

  spi_reg_dp #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .BACKED_MASK(BACKED_MASK)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .mosiBit (mosiBit),
    .miso    (spiMiso),
    .locAddr (locAddr),
    .locWe   (locWe),
    .locWdata(locWdata),
    .locRdata(locRdata)
  );

endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csCfg = 1'b0;
  logic        spiSclk = 1'b0;
  logic        spiCs = 1'b1;
  logic        spiMosi = 1'b0;
  logic        spiMiso;
  logic [4:0]  locAddr = '0;
  logic        locWe = 1'b0;
  logic [24:0] locWdata = '0;
  logic [24:0] locRdata;

  int  nChecks = 0;
  int  nFail = 0;
  bit  finished = 1'b0;

  always #4 clk = ~clk;

  spi_reg_slave i_spi_reg_slave (
    .clk(clk), .rstN(rstN), .csActiveHigh(csCfg),
    .spiSclk(spiSclk), .spiCs(spiCs), .spiMosi(spiMosi), .spiMiso(spiMiso),
    .locAddr(locAddr), .locWe(locWe), .locWdata(locWdata), .locRdata(locRdata)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wrWord(input logic [4:0] a, input logic [24:0] d);
    return {1'b1, a, 1'b0, d};
  endfunction

  function automatic logic [31:0] rdWord(input logic [4:0] a);
    return {1'b0, a, 26'h0};
  endfunction

  // Sends nBits MSB first (ones after the 32nd) and captures the reply.
  task automatic spiFrame(input logic [31:0] txWord, input int nBits, output logic [31:0] rxWord);
    rxWord = '0;
    spiCs = csCfg;
    idle(HALF);
    for (int i = 0; i < nBits; i++) begin
      spiMosi = (i < 32) ? txWord[31-i] : 1'b1;
      idle(HALF);
      if (i < 32) rxWord[31-i] = spiMiso;
      spiSclk = 1'b1;
      idle(HALF);
      spiSclk = 1'b0;
    end
    idle(HALF);
    spiCs = !csCfg;
    spiMosi = 1'b0;
    idle(4 * HALF);
  endtask

  task automatic locRead(input logic [4:0] a, output logic [24:0] v);
    locAddr = a;
    idle(1);
    v = locRdata;
  endtask

  task automatic locWrite(input logic [4:0] a, input logic [24:0] d);
    locAddr = a;
    locWdata = d;
    locWe = 1'b1;
    idle(1);
    locWe = 1'b0;
    idle(1);
  endtask

  task automatic testReset();
    logic [24:0] v;
    check("R1 miso after reset", {31'h0, spiMiso}, 32'h0);
    locRead(5'd0, v);  check("R1 reg0 reset", {7'h0, v}, 32'h0);
    locRead(5'd27, v); check("R1 reg27 reset", {7'h0, v}, 32'h0);
  endtask

  task automatic testWrite();
    logic [31:0] rx;
    logic [24:0] v;
    spiFrame(wrWord(5'd3, 25'h0123456), 32, rx);
    locRead(5'd3, v);
    check("R2 write reg3", {7'h0, v}, 32'h00123456);
  endtask

  task automatic testRead();
    logic [31:0] rx;
    logic [24:0] v;
    spiFrame(rdWord(5'd3), 32, rx);
    check("R3 read reply reg3", rx, 32'h00123456);
    locRead(5'd3, v);
    check("R3 read leaves reg3", {7'h0, v}, 32'h00123456);
  endtask

  task automatic testGapBit();
    logic [31:0] rx;
    logic [24:0] v;
    spiFrame(wrWord(5'd9, 25'h1ABCDEF) | 32'h0200_0000, 32, rx);
    locRead(5'd9, v);
    check("R4 gap bit not stored", {7'h0, v}, 32'h01ABCDEF);
    spiFrame(rdWord(5'd9), 32, rx);
    check("R4 reply bit25 clear", rx, 32'h01ABCDEF);
  endtask

  task automatic testWriteReturnsOld();
    logic [31:0] rx;
    logic [24:0] v;
    spiFrame(wrWord(5'd3, 25'h1555555), 32, rx);
    check("R5 write reply holds old value", rx, 32'h00123456);
    locRead(5'd3, v);
    check("R5 new value stored", {7'h0, v}, 32'h01555555);
  endtask

  task automatic testAbort();
    logic [31:0] rx;
    logic [24:0] v;
    spiFrame(wrWord(5'd3, 25'h0000001), 20, rx);
    locRead(5'd3, v);
    check("R7 aborted frame no update", {7'h0, v}, 32'h01555555);
    spiFrame(rdWord(5'd3), 32, rx);
    check("R7 next frame reads fine", rx, 32'h01555555);
  endtask

  task automatic testUnbacked();
    logic [31:0] rx;
    logic [24:0] v;
    spiFrame(wrWord(5'd30, 25'h1FFFFFF), 32, rx);
    spiFrame(rdWord(5'd30), 32, rx);
    check("R8 unbacked SPI read", rx, 32'h0);
    locWrite(5'd29, 25'h0000F0F);
    locRead(5'd29, v);
    check("R8 unbacked local read", {7'h0, v}, 32'h0);
  endtask

  task automatic testLocalPort();
    logic [31:0] rx;
    logic [24:0] v;
    locWrite(5'd12, 25'h155AA55);
    locRead(5'd12, v);
    check("R9 local write/read", {7'h0, v}, 32'h0155AA55);
    spiFrame(rdWord(5'd12), 32, rx);
    check("R9 local write seen by SPI", rx, 32'h0155AA55);
  endtask

  task automatic testPolarity();
    logic [31:0] rx;
    logic [24:0] v;
    csCfg = 1'b1;
    spiCs = 1'b0;
    idle(4 * HALF);
    spiMosi = 1'b1;
    for (int k = 0; k < 40; k++) begin
      spiSclk = ~spiSclk;
      idle(HALF);
    end
    spiMosi = 1'b0;
    idle(2 * HALF);
    locRead(5'd12, v);
    check("R6 edges with CS inactive ignored", {7'h0, v}, 32'h0155AA55);
    spiFrame(wrWord(5'd20, 25'h0F0F0F0), 32, rx);
    spiFrame(rdWord(5'd20), 32, rx);
    check("R6 active-high frame", rx, 32'h00F0F0F0);
  endtask

  task automatic testExtraBits();
    logic [31:0] rx;
    logic [24:0] v;
    spiFrame(wrWord(5'd7, 25'h0ABCDE1), 40, rx);
    locRead(5'd7, v);
    check("R10 bits past 32 ignored", {7'h0, v}, 32'h00ABCDE1);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    idle(5);
    rstN = 1'b1;
    idle(5);
    testReset();
    testWrite();
    testRead();
    testGapBit();
    testWriteReturnsOld();
    testAbort();
    testUnbacked();
    testLocalPort();
    testPolarity();
    testExtraBits();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      summary();
      $finish;
    end
  end

endmodule